// File: doc/BRIEF.md
# Multiple-input signature register

This block condenses a long stream of test responses into one short signature. Its register is a linear feedback shift register with the XOR gates placed between stages. Each clock it divides the accumulated data polynomial by a characteristic polynomial that is fixed at build time. After the final response word, the register holds the remainder of that division. This remainder is the signature, and the block compares it continuously against a golden value supplied from outside.

Two injection modes exist. In serial mode, a single response bit enters stage 0 on each enabled cycle, and the bit presented first is the highest-order coefficient. In parallel mode, every stage also XORs in its own bit of the response word. Because the register is linear, a whole bus compacts into one register. Before a run the register is loaded with a seed, normally zero. Producing the golden value is left to the user.

Top module: `sig_compactor`

## Requirements
- R1: While `rst_n` is low, `sig_o` is all zeros.
- R2: When `load_i` is high at a rising clock edge, `sig_o` takes the value of `seed_i` after that edge. Load wins over `en_i`.
- R3: On an enabled, non-load edge in serial mode (`multi_i`=0), the new value is the old value shifted up by one bit with `data_i[0]` placed in bit 0. The result is then XORed with `POLY` when the old bit W-1 was 1.
- R4: In serial mode, `data_i[W-1:1]` has no effect on `sig_o`.
- R5: In parallel mode (`multi_i`=1), the step of R3 is taken and then all of `data_i` is XORed in, so that bit i lands in stage i.
- R6: When `en_i` and `load_i` are both low at an edge, `sig_o` keeps its value, whatever `data_i` and `multi_i` are.
- R7: Start from a zero seed and feed a serial stream. `sig_o` then equals the remainder of the stream polynomial divided by x^W + `POLY`, where the first bit is the highest-order coefficient.
- R8: Start from a zero seed and run a parallel stream. `sig_o` then equals the XOR, taken over every lane i, of the remainder of that lane's bit stream multiplied by x^i.
- R9: `match_o` is 1 in the same cycle exactly when `sig_o` equals `golden_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load `seed_i` into the register |
| seed_i | input | W | Seed value |
| en_i | input | 1 | Compaction step enable |
| multi_i | input | 1 | 0 = serial injection, 1 = parallel injection |
| data_i | input | W | Response bits from the circuit under test |
| golden_i | input | W | Expected good-circuit signature |
| sig_o | output | W | Current register contents (the signature) |
| match_o | output | 1 | `sig_o` equals `golden_i` |

## Verification
The bench checks the remainder with a long-division model written separately from the design. A register that taps the wrong stage, or uses the wrong end of the register as feedback, would therefore leave a different remainder. In serial mode the upper data bits are driven with noise, so a design that leaks them into the register fails the per-cycle comparison. Parallel runs are checked against the XOR of per-lane remainders, which catches a lane wired to the wrong stage. Load asserted together with enable, and enable-low cycles carrying active data, expose a wrong priority and unwanted updates.

// File: rtl/misr_pkg.sv
package misr_pkg;

  typedef enum logic {
    INJ_SERIAL   = 1'b0,
    INJ_PARALLEL = 1'b1
  } inject_mode_e;

endpackage

// File: rtl/misr_inject.sv
module misr_inject
  import misr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         multi,
  input  logic [W-1:0] data,
  output logic [W-1:0] inj
);

  inject_mode_e mode;
  assign mode = inject_mode_e'(multi);

  // Lane 0 always carries data; the other lanes only in parallel mode.
  for (genvar i = 0; i < W; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign inj[i] = data[i];
    end else begin : g_rest
      assign inj[i] = (mode == INJ_PARALLEL) ? data[i] : 1'b0;
    end
  end

endmodule

// File: rtl/misr_core.sv
module misr_core #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  input  logic [W-1:0] inj,
  output logic [W-1:0] state
);

  logic [W-1:0] q;
  logic [W-1:0] nxt;
  logic         fb;

  assign fb = q[W-1];

  // The feedback XOR sits in front of every stage whose tap bit is set.
  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign nxt[i] = (POLY[i] & fb) ^ inj[i];
    end else begin : g_body
      assign nxt[i] = q[i-1] ^ (POLY[i] & fb) ^ inj[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= seed;
    else if (step) q <= nxt;
  end

  assign state = q;

endmodule

// File: rtl/misr_cmp.sv
module misr_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] sig,
  input  logic [W-1:0] golden,
  output logic         match
);

  assign match = (sig == golden);

endmodule

// File: rtl/sig_compactor.sv
module sig_compactor #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         en_i,
  input  logic         multi_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] golden_i,
  output logic [W-1:0] sig_o,
  output logic         match_o
);

  logic [W-1:0] inj_vec;
  logic         step_evt;

  assign step_evt = en_i & ~load_i;

  misr_inject #(.W(W)) u_inject (
    .multi (multi_i),
    .data  (data_i),
    .inj   (inj_vec)
  );

  misr_core #(.W(W), .POLY(POLY)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_i),
    .seed  (seed_i),
    .step  (step_evt),
    .inj   (inj_vec),
    .state (sig_o)
  );

  misr_cmp #(.W(W)) u_cmp (
    .sig    (sig_o),
    .golden (golden_i),
    .match  (match_o)
  );

endmodule

// File: rtl/sig_compactor_sva.sv
module sig_compactor_sva #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_i,
  input logic [W-1:0] seed_i,
  input logic         en_i,
  input logic         multi_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] golden_i,
  input logic [W-1:0] sig_o,
  input logic         match_o,
  input logic         step_evt
);

  p_reset_clear_r1: assert property (@(posedge clk) $rose(rst_n) |-> sig_o == '0);

  p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> sig_o == $past(seed_i));

  p_serial_step_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i && !multi_i) |=>
      sig_o == ({$past(sig_o[W-2:0]), $past(data_i[0])} ^ ($past(sig_o[W-1]) ? POLY : '0)));

  p_parallel_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !load_i && multi_i) |=>
      sig_o == ({$past(sig_o[W-2:0]), 1'b0} ^ ($past(sig_o[W-1]) ? POLY : '0) ^ $past(data_i)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !load_i) |=> $stable(sig_o));

  p_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_o == (sig_o == golden_i));

endmodule

bind sig_compactor sig_compactor_sva #(.W(W), .POLY(POLY)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_i   (load_i),
  .seed_i   (seed_i),
  .en_i     (en_i),
  .multi_i  (multi_i),
  .data_i   (data_i),
  .golden_i (golden_i),
  .sig_o    (sig_o),
  .match_o  (match_o),
  .step_evt (step_evt)
);

// File: tb/test_sig_compactor.sv
module test_sig_compactor;
  localparam int           W    = 16;
  localparam logic [W-1:0] POLY = 16'h1021;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] seed_i = '0;
  logic         en_i = 1'b0;
  logic         multi_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] golden_i = '0;
  logic [W-1:0] sig_o;
  logic         match_o;

  int total = 0;
  int bad = 0;
  logic [W-1:0] q_exp[$];
  string        q_tag[$];
  logic [W-1:0] mstate = '0;

  always #5 clk = ~clk;

  sig_compactor #(.W(W), .POLY(POLY)) i_sig_compactor (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i), .en_i(en_i),
    .multi_i(multi_i), .data_i(data_i), .golden_i(golden_i),
    .sig_o(sig_o), .match_o(match_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Model: multiply by x, add the injected bits, reduce modulo x^W + POLY.
  function automatic logic [W-1:0] model_step(input logic [W-1:0] s, input logic [W-1:0] b);
    logic [W:0] t;
    t = {s, 1'b0} ^ {1'b0, b};
    if (t[W]) t = t ^ {1'b1, POLY};
    return t[W-1:0];
  endfunction

  // Long division of a polynomial, highest coefficient in bit 63.
  function automatic logic [W-1:0] poly_rem(input logic [63:0] m);
    logic [63:0] dv;
    dv = {{(63-W){1'b0}}, 1'b1, POLY};
    for (int i = 63; i >= W; i--)
      if (m[i]) m = m ^ (dv << (i - W));
    return m[W-1:0];
  endfunction

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic drive(input logic ld, input logic [W-1:0] sd, input logic en,
                       input logic mul, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    load_i = ld; seed_i = sd; en_i = en; multi_i = mul; data_i = d;
    if (ld) mstate = sd;
    else if (en) mstate = model_step(mstate, mul ? d : {{(W-1){1'b0}}, d[0]});
    q_exp.push_back(mstate);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare after each rising edge.
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) chk(q_tag.pop_front(), sig_o, q_exp.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0]  msg;
    logic [W-1:0] words[8];
    logic [W-1:0] acc;
    logic [63:0]  lane;

    repeat (3) @(negedge clk);
    data_i = 16'hFFFF; en_i = 1'b1;
    @(negedge clk);
    chk("R1 reset", sig_o, '0);
    en_i = 1'b0;
    rst_n = 1'b1;

    // R2: load, then load priority over enable
    drive(1'b1, 16'hA5C3, 1'b0, 1'b0, 16'h0000, "R2 load");
    drive(1'b1, 16'h8001, 1'b1, 1'b1, 16'h1234, "R2 load over enable");
    // R3/R4: serial steps with noise on the upper data bits, MSB set at start
    for (int k = 0; k < 20; k++)
      drive(1'b0, '0, 1'b1, 1'b0, 16'($urandom) | 16'hFFFE * 16'(k % 2), "R3 R4 serial step");
    // R6: enable low with active data
    drive(1'b0, '0, 1'b0, 1'b1, 16'hDEAD, "R6 hold");
    drive(1'b0, '0, 1'b0, 1'b0, 16'hBEEF, "R6 hold");
    // R5: parallel steps
    for (int k = 0; k < 12; k++)
      drive(1'b0, '0, 1'b1, 1'b1, 16'($urandom), "R5 parallel step");

    // R9: match compare
    drive(1'b0, '0, 1'b0, 1'b0, '0, "R6 hold");
    @(negedge clk);
    golden_i = mstate; #1;
    chk("R9 match equal", {15'b0, match_o}, 16'd1);
    golden_i = mstate ^ 16'h0400; #1;
    chk("R9 match differ", {15'b0, match_o}, 16'd0);

    // R7: serial stream against long division
    drive(1'b1, '0, 1'b0, 1'b0, '0, "R2 zero seed");
    msg = '0;
    for (int k = 0; k < 48; k++) begin
      logic [W-1:0] d;
      d = 16'($urandom);
      msg = {msg[62:0], d[0]};
      drive(1'b0, '0, 1'b1, 1'b0, d, "R3 R4 stream step");
    end
    drive(1'b0, '0, 1'b0, 1'b0, '0, "R6 hold");
    @(negedge clk);
    chk("R7 remainder", sig_o, poly_rem(msg));

    // R8: parallel stream against per-lane superposition
    drive(1'b1, '0, 1'b0, 1'b0, '0, "R2 zero seed");
    for (int t = 0; t < 8; t++) begin
      words[t] = 16'($urandom);
      drive(1'b0, '0, 1'b1, 1'b1, words[t], "R5 stream step");
    end
    drive(1'b0, '0, 1'b0, 1'b0, '0, "R6 hold");
    @(negedge clk);
    acc = '0;
    for (int i = 0; i < W; i++) begin
      lane = '0;
      for (int t = 0; t < 8; t++)
        if (words[t][i]) lane = lane | (64'd1 << (7 - t + i));
      acc = acc ^ poly_rem(lane);
    end
    chk("R8 superposition", sig_o, acc);

    // R1 again: reset mid-run
    drive(1'b0, '0, 1'b1, 1'b1, 16'h5A5A, "R5 parallel step");
    @(negedge clk);
    rst_n = 1'b0; en_i = 1'b0; #1;
    chk("R1 async reset", sig_o, '0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule